// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Unit

This unit sits beside the control sequencer of a small 8-bit core. It decides which interrupt the core takes when an instruction finishes. It watches five hardware request lines: a non-maskable line, three maskable vectored lines and one non-vectored line. It also sees a software restart request issued by the restart instruction.

The unit applies three per-line mask bits and one global enable flag. The core raises a boundary strobe when an instruction completes. At that strobe the unit picks the winning request and presents its source code and 16-bit service address on a take output.

The non-vectored line has no fixed address. When it wins, the unit drives an active-low acknowledge and waits for the requesting device to supply an opcode. It then derives the service address from that opcode.

Two interfaces use valid/ready handshakes:
- **Take output.** The take output is a valid/ready stream. Once `take_valid` rises, the source and vector stay frozen until `take_ready` is seen high at a clock edge. While a take is waiting, or an acknowledge is open, boundary strobes are ignored, so the core applies back-pressure simply by holding `take_ready` low.
- **Opcode input.** During an acknowledge, `dev_ready` is high. The device's opcode is consumed on the first edge that has `dev_valid` high.

All request inputs are assumed synchronous to `clk`.

Top module: `vint_unit`

## Requirements
- R1: When several requests are live at one boundary, the winner is chosen in this order, highest first: `req_nmi`, `req_hi`, `req_mid`, `req_lo`, `req_ext`, software restart.
- R2: Fixed vectors are `req_nmi` 0x0024, `req_hi` 0x003C, `req_mid` 0x0034 and `req_lo` 0x002C.
- R3: `req_nmi` ignores the enable flag and the masks.
  - It is live only after a rising edge, and only while the pin is still high at the boundary.
  - Once it is taken, a pin held high does not fire again until it falls and rises.
- R4: The global enable flag behaves as follows.
  - It is set by `ien_set` and cleared by `ien_clr`.
  - When clear, it blocks every hardware line except `req_nmi`.
  - It is cleared automatically in the cycle any hardware request is accepted.
- R5: Mask bits behave as follows.
  - Mask bit 2 gates `req_hi`, bit 1 gates `req_mid` and bit 0 gates `req_lo`; a 1 blocks the line.
  - A `mask_wr` pulse loads `mask_data` only when `mask_set_en` is high. Otherwise the masks keep their value.
- R6: `req_hi` is caught by a rising-edge latch. The latch keeps the request after the pin drops, until the request is taken or until `mask_wr` is pulsed with `latch_clr` high.
- R7: `req_mid`, `req_lo` and `req_ext` are level-sensitive. Each is considered only if high in the boundary cycle.
- R8: Requests are evaluated only on a clock edge where `boundary` is high and the unit is idle (no waiting take, `ack_n` high). An accepted vectored request shows on `take_valid` one cycle later.
- R9: When `req_ext` wins, the acknowledge and opcode exchange runs as follows.
  - `ack_n` goes low one cycle after the boundary, with `dev_ready` high, and stays low until `dev_valid` is accepted.
  - A restart opcode `11nnn111` yields source code 5 and vector n*8.
  - Any other opcode yields source code 7 with the opcode as the vector.
  - The take appears one cycle after acceptance, and `ack_n` returns high.
- R10: A software restart `swi_num` = n is taken only when no hardware line wins. It yields vector n*8 and leaves the enable flag unchanged.
- R11: `take_src` encodes the source as follows: 1 non-maskable, 2 `req_hi`, 3 `req_mid`, 4 `req_lo`, 5 non-vectored restart, 6 software restart, 7 foreign opcode. Source and vector hold steady while `take_valid` is high and `take_ready` is low.
- R12: Reset leaves the enable flag clear, all three mask bits set, `take_valid` low and `ack_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_nmi | input | 1 | Non-maskable request, edge-and-level qualified |
| req_hi | input | 1 | Edge-latched maskable request, top maskable priority |
| req_mid | input | 1 | Level maskable request |
| req_lo | input | 1 | Level maskable request, lowest maskable priority |
| req_ext | input | 1 | Non-vectored level request needing acknowledge |
| mask_wr | input | 1 | Mask port write strobe |
| mask_set_en | input | 1 | Allows `mask_data` to load on a write |
| mask_data | input | 3 | New mask bits {hi, mid, lo} |
| latch_clr | input | 1 | Clears the `req_hi` latch on a write |
| ien_set | input | 1 | Sets the global enable flag |
| ien_clr | input | 1 | Clears the global enable flag |
| boundary | input | 1 | Instruction-complete strobe from the core |
| swi_req | input | 1 | Software restart request at this boundary |
| swi_num | input | 3 | Restart number of the software request |
| take_valid | output | 1 | A chosen interrupt is presented |
| take_ready | input | 1 | Core accepts the presented interrupt |
| take_src | output | 3 | Source code of the presented interrupt |
| take_vec | output | 16 | Service address, or foreign opcode |
| ack_n | output | 1 | Active-low acknowledge to the non-vectored device |
| dev_valid | input | 1 | Device presents an opcode |
| dev_ready | output | 1 | Unit accepts the opcode |
| dev_opc | input | 8 | Opcode supplied by the device |

## Verification
A table drives every line alone, then the lines stacked from the top downward. This separates a priority slip from a wrong vector. The same stacks are run with the enable flag off and with growing mask patterns, which shows whether gating drops a line or merely reorders it.

Directed cases cover the following:
- A non-maskable pin held high across two boundaries.
- A pulse on the edge-latched line that falls before the boundary.
- A level pulse that does the same.
- A mask write without its set-enable.

These separate edge capture from level sampling. Busy-period boundaries, a stalled acknowledge and a non-restart opcode probe the two handshakes.

// File: rtl/vint_pkg.sv
package vint_pkg;

  localparam int VEC_W    = 16;
  localparam int OPC_W    = 8;
  localparam int NUM_MASK = 3;
  localparam int RST_NW   = 3;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4,
    SRC_EXT  = 3'd5,
    SRC_SWI  = 3'd6,
    SRC_OPC  = 3'd7
  } src_e;

  // restart slots are spaced eight bytes apart from address zero
  function automatic logic [VEC_W-1:0] restart_vec(input logic [RST_NW-1:0] n);
    return VEC_W'({n, 3'b000});
  endfunction

endpackage

// File: rtl/vint_edge_latch.sv
module vint_edge_latch #(
  parameter bit HOLD_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);

  logic prev_q;
  logic flag_q;
  logic rise;

  assign rise = pin & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin;
      if (rise)
        flag_q <= 1'b1;
      else if (clr)
        flag_q <= 1'b0;
      else if (HOLD_LEVEL && !pin)
        flag_q <= 1'b0;
    end
  end

  generate
    if (HOLD_LEVEL) begin : g_qualified
      assign pend = flag_q & pin;
    end else begin : g_sticky
      assign pend = flag_q;
    end
  endgenerate

endmodule

// File: rtl/vint_prio.sv
module vint_prio
  import vint_pkg::*;
#(
  parameter int               VW       = VEC_W,
  parameter logic [VW-1:0]    TRAP_VEC = 16'h0024,
  parameter logic [VW-1:0]    HI_VEC   = 16'h003C,
  parameter logic [VW-1:0]    MID_VEC  = 16'h0034,
  parameter logic [VW-1:0]    LO_VEC   = 16'h002C
) (
  input  logic                trap_p,
  input  logic                hi_p,
  input  logic                mid_p,
  input  logic                lo_p,
  input  logic                ext_p,
  input  logic                ien,
  input  logic [NUM_MASK-1:0] mask,
  input  logic                swi_req,
  input  logic [RST_NW-1:0]   swi_num,
  output src_e                sel_src,
  output logic [VW-1:0]       sel_vec
);

  localparam logic [VW-1:0] MVEC [NUM_MASK] = '{LO_VEC, MID_VEC, HI_VEC};
  localparam src_e          MSRC [NUM_MASK] = '{SRC_LO, SRC_MID, SRC_HI};

  logic [NUM_MASK-1:0] mlive;

  assign mlive = {hi_p, mid_p, lo_p} & ~mask & {NUM_MASK{ien}};

  // later assignments override earlier ones: lowest priority first
  always_comb begin
    sel_src = SRC_NONE;
    sel_vec = '0;
    if (swi_req) begin
      sel_src = SRC_SWI;
      sel_vec = VW'(restart_vec(swi_num));
    end
    if (ext_p && ien) begin
      sel_src = SRC_EXT;
      sel_vec = '0;
    end
    for (int i = 0; i < NUM_MASK; i++) begin
      if (mlive[i]) begin
        sel_src = MSRC[i];
        sel_vec = MVEC[i];
      end
    end
    if (trap_p) begin
      sel_src = SRC_TRAP;
      sel_vec = TRAP_VEC;
    end
  end

endmodule

// File: rtl/vint_ack_seq.sv
module vint_ack_seq
  import vint_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dev_valid,
  input  logic [OW-1:0] dev_opc,
  output logic          ack_n,
  output logic          dev_ready,
  output logic          done,
  output src_e          done_src,
  output logic [VW-1:0] done_vec
);

  logic active_q;
  logic is_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= 1'b0;
    else if (start)
      active_q <= 1'b1;
    else if (active_q && dev_valid)
      active_q <= 1'b0;
  end

  assign ack_n     = ~active_q;
  assign dev_ready = active_q;
  assign done      = active_q & dev_valid;

  // restart opcode pattern: 11 nnn 111
  assign is_restart = (dev_opc[OW-1 -: 2] == 2'b11) && (dev_opc[2:0] == 3'b111);

  always_comb begin
    if (is_restart) begin
      done_src = SRC_EXT;
      done_vec = VW'(restart_vec(dev_opc[5:3]));
    end else begin
      done_src = SRC_OPC;
      done_vec = VW'(dev_opc);
    end
  end

endmodule

// File: rtl/vint_unit.sv
module vint_unit
  import vint_pkg::*;
#(
  parameter int               VW       = VEC_W,
  parameter int               OW       = OPC_W,
  parameter logic [VW-1:0]    TRAP_VEC = 16'h0024,
  parameter logic [VW-1:0]    HI_VEC   = 16'h003C,
  parameter logic [VW-1:0]    MID_VEC  = 16'h0034,
  parameter logic [VW-1:0]    LO_VEC   = 16'h002C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_nmi,
  input  logic                req_hi,
  input  logic                req_mid,
  input  logic                req_lo,
  input  logic                req_ext,
  input  logic                mask_wr,
  input  logic                mask_set_en,
  input  logic [NUM_MASK-1:0] mask_data,
  input  logic                latch_clr,
  input  logic                ien_set,
  input  logic                ien_clr,
  input  logic                boundary,
  input  logic                swi_req,
  input  logic [RST_NW-1:0]   swi_num,
  output logic                take_valid,
  input  logic                take_ready,
  output logic [2:0]          take_src,
  output logic [VW-1:0]       take_vec,
  output logic                ack_n,
  input  logic                dev_valid,
  output logic                dev_ready,
  input  logic [OW-1:0]       dev_opc
);

  logic                trap_p;
  logic                hi_p;
  logic                trap_clr;
  logic                hi_clr;
  logic                ien_q;
  logic [NUM_MASK-1:0] mask_q;
  src_e                sel_src;
  logic [VW-1:0]       sel_vec;
  logic                busy;
  logic                accept;
  logic                hw_take;
  logic                ack_start;
  logic                load_now;
  logic                ack_done;
  src_e                ack_src;
  logic [VW-1:0]       ack_vec;
  logic                tv_q;
  src_e                ts_q;
  logic [VW-1:0]       tvec_q;

  assign busy      = tv_q | ~ack_n;
  assign accept    = boundary & ~busy;
  assign hw_take   = accept && (sel_src != SRC_NONE) && (sel_src != SRC_SWI);
  assign ack_start = accept && (sel_src == SRC_EXT);
  assign load_now  = accept && (sel_src != SRC_NONE) && (sel_src != SRC_EXT);
  assign trap_clr  = accept && (sel_src == SRC_TRAP);
  assign hi_clr    = (accept && (sel_src == SRC_HI)) || (mask_wr && latch_clr);

  vint_edge_latch #(.HOLD_LEVEL(1'b1)) u_trap_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (req_nmi),
    .clr  (trap_clr),
    .pend (trap_p)
  );

  vint_edge_latch #(.HOLD_LEVEL(1'b0)) u_hi_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (req_hi),
    .clr  (hi_clr),
    .pend (hi_p)
  );

  vint_prio #(
    .VW      (VW),
    .TRAP_VEC(TRAP_VEC),
    .HI_VEC  (HI_VEC),
    .MID_VEC (MID_VEC),
    .LO_VEC  (LO_VEC)
  ) u_prio (
    .trap_p (trap_p),
    .hi_p   (hi_p),
    .mid_p  (req_mid),
    .lo_p   (req_lo),
    .ext_p  (req_ext),
    .ien    (ien_q),
    .mask   (mask_q),
    .swi_req(swi_req),
    .swi_num(swi_num),
    .sel_src(sel_src),
    .sel_vec(sel_vec)
  );

  vint_ack_seq #(.OW(OW), .VW(VW)) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ack_start),
    .dev_valid(dev_valid),
    .dev_opc  (dev_opc),
    .ack_n    (ack_n),
    .dev_ready(dev_ready),
    .done     (ack_done),
    .done_src (ack_src),
    .done_vec (ack_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ien_q <= 1'b0;
    else if (hw_take || ien_clr)
      ien_q <= 1'b0;
    else if (ien_set)
      ien_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (mask_wr && mask_set_en)
      mask_q <= mask_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q   <= 1'b0;
      ts_q   <= SRC_NONE;
      tvec_q <= '0;
    end else if (load_now) begin
      tv_q   <= 1'b1;
      ts_q   <= sel_src;
      tvec_q <= sel_vec;
    end else if (ack_done) begin
      tv_q   <= 1'b1;
      ts_q   <= ack_src;
      tvec_q <= ack_vec;
    end else if (tv_q && take_ready) begin
      tv_q   <= 1'b0;
    end
  end

  assign take_valid = tv_q;
  assign take_src   = ts_q;
  assign take_vec   = tvec_q;

endmodule

// File: rtl/vint_checker.sv
module vint_checker #(
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          req_nmi,
  input logic          take_valid,
  input logic          take_ready,
  input logic [2:0]    take_src,
  input logic [VW-1:0] take_vec,
  input logic          ack_n,
  input logic          dev_valid
);

  p_take_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && !take_ready |=> take_valid && $stable(take_vec) && $stable(take_src));

  p_take_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(boundary) || $past(dev_valid));

  p_ack_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(boundary));

  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(dev_valid) && take_valid);

  p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !take_valid);

  p_trap_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_src == 3'd1 |-> take_vec == 16'h0024);

  p_hi_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_src == 3'd2 |-> take_vec == 16'h003C);

  p_mid_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_src == 3'd3 |-> take_vec == 16'h0034);

  p_lo_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_src == 3'd4 |-> take_vec == 16'h002C);

  p_trap_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) && take_src == 3'd1 |-> $past(req_nmi));

endmodule

bind vint_unit vint_checker #(.VW(VW)) i_vint_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .boundary  (boundary),
  .req_nmi   (req_nmi),
  .take_valid(take_valid),
  .take_ready(take_ready),
  .take_src  (take_src),
  .take_vec  (take_vec),
  .ack_n     (ack_n),
  .dev_valid (dev_valid)
);

// File: tb/test_vint_unit.sv
`timescale 1ns/100ps
module test_vint_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_nmi = 0, req_hi = 0, req_mid = 0, req_lo = 0, req_ext = 0;
  logic        mask_wr = 0, mask_set_en = 0, latch_clr = 0;
  logic [2:0]  mask_data = 0;
  logic        ien_set = 0, ien_clr = 0, boundary = 0, swi_req = 0;
  logic [2:0]  swi_num = 0;
  logic        take_valid, take_ready = 0;
  logic [2:0]  take_src;
  logic [15:0] take_vec;
  logic        ack_n, dev_valid = 0, dev_ready;
  logic [7:0]  dev_opc = 0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vint_unit i_vint_unit (
    .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_hi(req_hi), .req_mid(req_mid),
    .req_lo(req_lo), .req_ext(req_ext), .mask_wr(mask_wr), .mask_set_en(mask_set_en),
    .mask_data(mask_data), .latch_clr(latch_clr), .ien_set(ien_set), .ien_clr(ien_clr),
    .boundary(boundary), .swi_req(swi_req), .swi_num(swi_num), .take_valid(take_valid),
    .take_ready(take_ready), .take_src(take_src), .take_vec(take_vec), .ack_n(ack_n),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_opc(dev_opc)
  );

  // row: [31:27] pins {nmi,hi,mid,lo,ext} [26] swi [25:23] swi_num [22] ien
  //      [21:19] mask [18:16] expected src [15:0] expected vector
  localparam int NROW = 14;
  localparam logic [31:0] TBL [NROW] = '{
    {5'b11111, 1'b0, 3'd0, 1'b1, 3'b000, 3'd1, 16'h0024},  // R1 all live
    {5'b01111, 1'b0, 3'd0, 1'b1, 3'b000, 3'd2, 16'h003C},  // R1
    {5'b00111, 1'b0, 3'd0, 1'b1, 3'b000, 3'd3, 16'h0034},  // R1
    {5'b00011, 1'b0, 3'd0, 1'b1, 3'b000, 3'd4, 16'h002C},  // R1
    {5'b00001, 1'b0, 3'd0, 1'b1, 3'b000, 3'd5, 16'h0028},  // R9 device gives 0xEF
    {5'b11111, 1'b0, 3'd0, 1'b0, 3'b000, 3'd1, 16'h0024},  // R3 enable off
    {5'b01111, 1'b0, 3'd0, 1'b0, 3'b000, 3'd0, 16'h0000},  // R4 enable off
    {5'b01111, 1'b0, 3'd0, 1'b1, 3'b100, 3'd3, 16'h0034},  // R5
    {5'b01111, 1'b0, 3'd0, 1'b1, 3'b110, 3'd4, 16'h002C},  // R5
    {5'b01111, 1'b0, 3'd0, 1'b1, 3'b111, 3'd5, 16'h0028},  // R5 only ext left
    {5'b00000, 1'b1, 3'd3, 1'b0, 3'b111, 3'd6, 16'h0018},  // R10
    {5'b00010, 1'b1, 3'd7, 1'b1, 3'b000, 3'd4, 16'h002C},  // R10 loses
    {5'b00000, 1'b1, 3'd0, 1'b1, 3'b000, 3'd6, 16'h0000},  // R10
    {5'b10000, 1'b0, 3'd0, 1'b0, 3'b111, 3'd1, 16'h0024}   // R3 masks ignored
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic set_pins(input logic [4:0] p);
    {req_nmi, req_hi, req_mid, req_lo, req_ext} = p;
  endtask

  task automatic write_mask(input logic [2:0] m, input logic en, input logic clr);
    mask_wr = 1; mask_data = m; mask_set_en = en; latch_clr = clr;
    tick();
    mask_wr = 0; mask_set_en = 0; latch_clr = 0;
  endtask

  task automatic set_ien(input logic on);
    if (on) ien_set = 1; else ien_clr = 1;
    tick();
    ien_set = 0; ien_clr = 0;
  endtask

  task automatic strobe(input logic sw, input logic [2:0] n);
    boundary = 1; swi_req = sw; swi_num = n;
    tick();
    boundary = 0; swi_req = 0;
  endtask

  task automatic expect_take(input string tag, input logic [2:0] src, input logic [15:0] vec);
    check({tag, " take_valid"}, take_valid, 1);
    check({tag, " take_src"}, take_src, src);
    check({tag, " take_vec"}, take_vec, vec);
    take_ready = 1;
    tick();
    take_ready = 0;
  endtask

  task automatic expect_none(input string tag);
    check({tag, " no take"}, take_valid, 0);
    check({tag, " ack idle"}, ack_n, 1);
  endtask

  task automatic supply_opc(input logic [7:0] opc);
    dev_valid = 1; dev_opc = opc;
    tick();
    dev_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R12 reset take_valid", take_valid, 0);
    check("R12 reset ack_n", ack_n, 1);
    check("R12 reset dev_ready", dev_ready, 0);
    rst_n = 1;
    tick();

    // R12: enable off and masks set after reset
    set_pins(5'b00100);
    tick();
    strobe(0, 0);
    expect_none("R12 enable clear");
    set_ien(1);
    strobe(0, 0);
    expect_none("R12 masks set");
    write_mask(3'b000, 1, 0);
    strobe(0, 0);
    expect_take("R5 mask opened", 3'd3, 16'h0034);
    set_pins(0);

    // table walk
    for (int i = 0; i < NROW; i++) begin
      logic [31:0] row;
      string tag;
      row = TBL[i];
      tag = $sformatf("R1 R2 row %0d", i);
      set_pins(0);
      write_mask(row[21:19], 1, 1);
      set_ien(row[22]);
      set_pins(row[31:27]);
      tick();
      strobe(row[26], row[25:23]);
      if (row[18:16] == 3'd5) begin
        check({tag, " R9 ack low"}, ack_n, 0);
        check({tag, " R9 dev_ready"}, dev_ready, 1);
        supply_opc(8'hEF);
        check({tag, " R9 ack released"}, ack_n, 1);
        expect_take(tag, 3'd5, row[15:0]);
      end else if (row[18:16] == 3'd0) begin
        expect_none(tag);
      end else begin
        expect_take(tag, row[18:16], row[15:0]);
      end
      set_pins(0);
    end

    // R3: held-high non-maskable pin fires once
    write_mask(3'b000, 1, 1);
    req_nmi = 1;
    tick();
    strobe(0, 0);
    expect_take("R3 first edge", 3'd1, 16'h0024);
    strobe(0, 0);
    expect_none("R3 held high");
    req_nmi = 0;
    tick();
    req_nmi = 1;
    tick();
    strobe(0, 0);
    expect_take("R3 second edge", 3'd1, 16'h0024);
    req_nmi = 0;
    tick();

    // R3: pulse gone before boundary
    req_nmi = 1;
    tick();
    req_nmi = 0;
    tick();
    strobe(0, 0);
    expect_none("R3 fallen pulse");

    // R6: edge latch keeps a short pulse until taken
    set_ien(1);
    req_hi = 1;
    tick();
    req_hi = 0;
    tick();
    strobe(0, 0);
    expect_take("R6 latched pulse", 3'd2, 16'h003C);
    set_ien(1);
    strobe(0, 0);
    expect_none("R6 cleared by service");

    // R6: latch cleared through mask port; R5 write without set-enable
    req_hi = 1;
    tick();
    req_hi = 0;
    write_mask(3'b111, 0, 1);
    strobe(0, 0);
    expect_none("R6 latch cleared");
    req_mid = 1;
    tick();
    strobe(0, 0);
    expect_take("R5 masks kept", 3'd3, 16'h0034);
    req_mid = 0;

    // R7: level pulse dropped before boundary
    set_ien(1);
    req_lo = 1;
    tick();
    req_lo = 0;
    tick();
    strobe(0, 0);
    expect_none("R7 level dropped");

    // R4: enable cleared by acceptance, then restored
    req_lo = 1;
    strobe(0, 0);
    expect_take("R4 first take", 3'd4, 16'h002C);
    strobe(0, 0);
    expect_none("R4 auto disable");
    set_ien(1);
    strobe(0, 0);
    expect_take("R4 re-enabled", 3'd4, 16'h002C);
    req_lo = 0;

    // R8: no evaluation without a boundary
    set_ien(1);
    req_mid = 1;
    repeat (3) tick();
    expect_none("R8 no boundary");
    req_mid = 0;

    // R11 / R8: take held under back-pressure, busy boundary ignored
    req_lo = 1;
    strobe(0, 0);
    req_lo = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R11 hold valid", take_valid, 1);
      check("R11 hold vec", take_vec, 16'h002C);
    end
    req_nmi = 1;
    tick();
    strobe(0, 0);
    take_ready = 1;
    tick();
    take_ready = 0;
    check("R8 busy boundary ignored", take_valid, 0);
    strobe(0, 0);
    expect_take("R8 after idle", 3'd1, 16'h0024);
    req_nmi = 0;

    // R9: stalled device, then a foreign opcode
    set_ien(1);
    req_ext = 1;
    strobe(0, 0);
    req_ext = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R9 ack held", ack_n, 0);
      check("R9 no take yet", take_valid, 0);
    end
    supply_opc(8'h3E);
    check("R9 ack back", ack_n, 1);
    expect_take("R9 foreign opcode", 3'd7, 16'h003E);

    // R10: software restart keeps enable
    set_ien(1);
    strobe(1, 3'd2);
    expect_take("R10 restart", 3'd6, 16'h0010);
    req_lo = 1;
    strobe(0, 0);
    expect_take("R10 enable kept", 3'd4, 16'h002C);
    req_lo = 0;
    tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule